// File: doc/BRIEF.md
# Version and NMI Trigger Control Slice

This block is a small register slice on an APB bus. It exposes an identification word and an interrupt trigger selector for one external non-maskable interrupt pin, and it drives a single interrupt line towards the interrupt controller. Both external pins, the boot-mode strap and the NMI input, are brought into the bus clock domain through two-stage synchronisers. The strap pin is reported raw, with no filtering.

The identification word carries a fixed revision byte, the synchronised strap level and a software-owned unlock bit. While the unlock bit is set, the upper half of the word returns a fixed 16-bit key. Otherwise that half reads as zero. The trigger selector picks one of four ways to raise the interrupt. Two are level modes, in which the output follows the synchronised pin. Two are edge modes, in which a sticky pending flag is set on the chosen edge and software clears it through a status word.

Top module: `ver_nmi_ctl`

## Requirements
- R1: After reset the unlock bit is 0 and the trigger code is 00. The pending flag is 0. With both pins held high, the identification word at 0x24 reads 0x0000_0100 (revision parameter 0x00), and 0x30 and 0x34 read 0.
- R2: Bit 15 of the word at 0x24 is read/write. Bits [31:16] read as the key 0x1651 while bit 15 is 1 and read as 0 while bit 15 is 0.
- R3: Bits [14:9] of the word at 0x24 always read 0. A write there changes only bit 15.
- R4: Bit 8 of the word at 0x24 reports the boot-strap pin level after two clocks of synchronisation.
- R5: Bits [7:0] of the word at 0x24 always return the revision parameter (default 0x00), whatever is written.
- R6: Bits [1:0] of the word at 0x30 hold the trigger code and are read/write. Bits [31:2] read 0.
- R7: With trigger code 00 the interrupt output equals the inverse of the synchronised NMI pin. With code 10 it equals the synchronised pin. In both cases the output changes two clocks after the pin and the pending flag stays 0.
- R8: With code 01 a falling edge sets the pending flag, and with code 11 a rising edge sets it. The flag is set three clocks after the pin changes, the opposite edge has no effect, and the interrupt output equals the flag.
- R9: Bit 0 of the word at 0x34 reads the pending flag. Writing 1 there clears it, and writing 0 has no effect. A new edge in the same cycle as the clearing write leaves the flag set.
- R10: A write to 0x30 that changes the trigger code clears the pending flag. Rewriting the same code keeps it.
- R11: Any access to an offset other than 0x24, 0x30 and 0x34 reads 0, and writes to such offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero when not selected |
| boot_pin | input | 1 | Asynchronous boot-mode strap |
| nmi_pin | input | 1 | Asynchronous NMI input |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench measures pin-to-interrupt latency to the exact clock. A missing or extra synchroniser stage would move the output one cycle early or late. It aims a clearing write at the very cycle an edge is detected, so a design that let the clear win would drop a real event. It also rewrites the trigger code with the same value and with a new value, which catches a design that clears on every write or never clears. Finally, it feeds the opposite edge in each edge mode and writes all ones to read-only, reserved and unmapped locations, which exposes swapped polarity decoding and leaky write masks.

// File: rtl/ver_nmi_pkg.sv
package ver_nmi_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_HIGH = 2'b10,
        TRIG_RISE = 2'b11
    } trig_e;

    typedef struct packed {
        logic  unlock;
        trig_e trig;
    } cfg_t;

endpackage

// File: rtl/vn_sync.sv
module vn_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/vn_nmi_det.sv
module vn_nmi_det
    import ver_nmi_pkg::*;
#(
    parameter logic RST_VAL = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin_s,
    input  trig_e trig,
    input  logic  ack,
    input  logic  trig_chg,
    output logic  pending_o,
    output logic  irq_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } det_t;

    det_t st_d, st_q;
    logic rise_ev, fall_ev, hit;

    always_comb begin
        rise_ev = pin_s & ~st_q.prev;
        fall_ev = ~pin_s & st_q.prev;
        hit     = ((trig == TRIG_RISE) & rise_ev) | ((trig == TRIG_FALL) & fall_ev);

        st_d      = st_q;
        st_d.prev = pin_s;
        if (trig_chg)  st_d.pend = 1'b0;
        else if (hit)  st_d.pend = 1'b1;
        else if (ack)  st_d.pend = 1'b0;

        unique case (trig)
            TRIG_LOW:  irq_o = ~pin_s;
            TRIG_HIGH: irq_o = pin_s;
            default:   irq_o = st_q.pend;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: RST_VAL, pend: 1'b0};
        else        st_q <= st_d;
    end

    assign pending_o = st_q.pend;

    // R8: the selected edge raises the flag on the following clock
    a_r8_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_RISE && pin_s && !st_q.prev && !trig_chg) |=> st_q.pend);
    a_r8_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_FALL && !pin_s && st_q.prev && !trig_chg) |=> st_q.pend);
    // R7: level modes never hold a pending event
    a_r7_level_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (trig[0] == 1'b0) |-> !st_q.pend);
    // R10: a new trigger code wipes the flag
    a_r10_chg_clears: assert property (@(posedge clk) disable iff (!rst_n)
        trig_chg |=> !st_q.pend);
    // R9: acknowledge without a concurrent edge clears the flag
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && pin_s == st_q.prev) |=> !st_q.pend);
endmodule

// File: rtl/ver_nmi_ctl.sv
module ver_nmi_ctl
    import ver_nmi_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter logic [7:0]  REVISION    = 8'h00,
    parameter logic [15:0] UNLOCK_KEY  = 16'h1651,
    parameter int          SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] OFF_IDENT = ADDR_W'('h24),
    parameter logic [ADDR_W-1:0] OFF_TRIG  = ADDR_W'('h30),
    parameter logic [ADDR_W-1:0] OFF_STAT  = ADDR_W'('h34)
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic              boot_pin,
    input  logic              nmi_pin,
    output logic              irq_o
);
    localparam int UNLOCK_BIT = 15;
    localparam int STRAP_BIT  = 8;

    cfg_t cfg_d, cfg_q;
    logic boot_s, nmi_s, pending;
    logic wr_en, sel_ident, sel_trig, sel_stat;
    logic trig_chg, ack;

    vn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_boot_sync (
        .clk(pclk), .rst_n(presetn), .din(boot_pin), .dout(boot_s));

    vn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nmi_sync (
        .clk(pclk), .rst_n(presetn), .din(nmi_pin), .dout(nmi_s));

    always_comb begin
        sel_ident = (paddr == OFF_IDENT);
        sel_trig  = (paddr == OFF_TRIG);
        sel_stat  = (paddr == OFF_STAT);
        wr_en     = psel & penable & pwrite;

        cfg_d    = cfg_q;
        trig_chg = 1'b0;
        ack      = wr_en & sel_stat & pwdata[0];
        if (wr_en && sel_ident) cfg_d.unlock = pwdata[UNLOCK_BIT];
        if (wr_en && sel_trig) begin
            cfg_d.trig = trig_e'(pwdata[1:0]);
            trig_chg   = (pwdata[1:0] != cfg_q.trig);
        end

        prdata = '0;
        if (psel) begin
            if (sel_ident) begin
                prdata[7:0]        = REVISION;
                prdata[STRAP_BIT]  = boot_s;
                prdata[UNLOCK_BIT] = cfg_q.unlock;
                prdata[31:16]      = cfg_q.unlock ? UNLOCK_KEY : 16'h0;
            end else if (sel_trig) begin
                prdata[1:0] = cfg_q.trig;
            end else if (sel_stat) begin
                prdata[0] = pending;
            end
        end
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) cfg_q <= '{unlock: 1'b0, trig: TRIG_LOW};
        else          cfg_q <= cfg_d;
    end

    vn_nmi_det #(.RST_VAL(1'b1)) u_det (
        .clk(pclk), .rst_n(presetn), .pin_s(nmi_s), .trig(cfg_q.trig),
        .ack(ack), .trig_chg(trig_chg), .pending_o(pending), .irq_o(irq_o));

    // R2: the unlock bit takes the written value
    a_r2_unlock_write: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pwrite && paddr == OFF_IDENT) |=> cfg_q.unlock == $past(pwdata[UNLOCK_BIT]));
    // R11: unmapped offsets return zero
    a_r11_unmapped_zero: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && paddr != OFF_IDENT && paddr != OFF_TRIG && paddr != OFF_STAT) |-> prdata == 32'h0);
    // R6: trigger code only moves on a write to its own offset
    a_r6_trig_hold: assert property (@(posedge pclk) disable iff (!presetn)
        !(psel && penable && pwrite && paddr == OFF_TRIG) |=> $stable(cfg_q.trig));
endmodule

// File: tb/ver_nmi_ctl_bench.sv
module ver_nmi_ctl_bench;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        boot_pin = 1'b1, nmi_pin = 1'b1;
    logic        irq_o;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 pclk = ~pclk;

    ver_nmi_ctl u_ver_nmi_ctl (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .boot_pin(boot_pin), .nmi_pin(nmi_pin), .irq_o(irq_o));

    // monitor: compares read data in the access phase against the queue
    always @(negedge pclk) begin
        if (psel && penable && !pwrite) begin
            n_checks++;
            if (sb_q.size() == 0) begin
                n_err++;
                $display("FAIL scoreboard: unexpected read, actual %h expected none", prdata);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (prdata !== e.exp) begin
                    n_err++;
                    $display("FAIL %s: actual %h expected %h", e.tag, prdata, e.exp);
                end
            end
        end
    end

    task automatic apb(input logic wr, input logic [7:0] a, input logic [31:0] d);
        @(posedge pclk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(posedge pclk); #1;
        penable = 1'b1;
        @(posedge pclk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        apb(1'b1, a, d);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        e.exp = exp; e.tag = tag;
        sb_q.push_back(e);
        apb(1'b0, a, 32'h0);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge pclk);
        n_checks++;
        if (irq_o !== exp) begin
            n_err++;
            $display("FAIL %s: actual irq %b expected %b", tag, irq_o, exp);
        end
    endtask

    task automatic pin_set(input logic v);
        @(posedge pclk); #1;
        nmi_pin = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge pclk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge pclk);
        #1 presetn = 1'b1;
        repeat (3) @(posedge pclk);

        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd(8'h24, 32'h0000_0100, "R1 ident reset");
        rd(8'h30, 32'h0, "R1 trig reset");
        rd(8'h34, 32'h0, "R1 stat reset");

        // R2 unlock key
        wr(8'h24, 32'h0000_8000);
        rd(8'h24, 32'h1651_8100, "R2 key visible");
        wr(8'h24, 32'h0);
        rd(8'h24, 32'h0000_0100, "R2 key hidden");

        // R3 R5 read-only and reserved bits ignore writes
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, 32'h1651_8100, "R3 R5 write mask");
        wr(8'h24, 32'hFFFF_7FFF);
        rd(8'h24, 32'h0000_0100, "R3 only unlock moves");

        // R4 strap pin
        boot_pin = 1'b0;
        repeat (3) @(posedge pclk);
        rd(8'h24, 32'h0000_0000, "R4 strap low");
        boot_pin = 1'b1;
        repeat (3) @(posedge pclk);
        rd(8'h24, 32'h0000_0100, "R4 strap high");

        // R6 trigger code field
        wr(8'h30, 32'hFFFF_FFFE);
        rd(8'h30, 32'h0000_0002, "R6 code readback");

        // R7 high level, exact latency
        chk_irq(1'b1, "R7 high level active");
        pin_set(1'b0);
        @(posedge pclk); chk_irq(1'b1, "R7 one clock still old");
        @(posedge pclk); chk_irq(1'b0, "R7 two clocks follows pin");
        rd(8'h34, 32'h0, "R7 no pending in level mode");
        wr(8'h30, 32'h0);
        chk_irq(1'b1, "R7 low level active");
        pin_set(1'b1);
        repeat (2) @(posedge pclk);
        chk_irq(1'b0, "R7 low level released");

        // R8 rising edge
        pin_set(1'b0);
        wr(8'h30, 32'h3);
        repeat (3) @(posedge pclk);
        chk_irq(1'b0, "R8 rise mode idle");
        pin_set(1'b1);
        repeat (2) @(posedge pclk); chk_irq(1'b0, "R8 not yet pending");
        @(posedge pclk);           chk_irq(1'b1, "R8 rise sets pending");
        pin_set(1'b0);
        repeat (4) @(posedge pclk);
        chk_irq(1'b1, "R8 pending is sticky");
        rd(8'h34, 32'h1, "R9 stat shows pending");

        // R9 acknowledge
        wr(8'h34, 32'h0);
        rd(8'h34, 32'h1, "R9 write zero no effect");
        wr(8'h34, 32'h1);
        rd(8'h34, 32'h0, "R9 write one clears");
        chk_irq(1'b0, "R9 irq drops after ack");

        // R8 opposite edge in rise mode: pin is low, raise then drop, clear, drop again ignored
        pin_set(1'b1);
        repeat (4) @(posedge pclk);
        wr(8'h34, 32'h1);
        pin_set(1'b0);
        repeat (4) @(posedge pclk);
        chk_irq(1'b0, "R8 falling ignored in rise mode");

        // R8 falling mode
        wr(8'h30, 32'h1);
        pin_set(1'b1);
        repeat (4) @(posedge pclk);
        chk_irq(1'b0, "R8 rising ignored in fall mode");
        pin_set(1'b0);
        repeat (3) @(posedge pclk);
        chk_irq(1'b1, "R8 fall sets pending");

        // R10 same code keeps, new code clears
        wr(8'h30, 32'h1);
        rd(8'h34, 32'h1, "R10 same code keeps pending");
        wr(8'h30, 32'h3);
        rd(8'h34, 32'h0, "R10 new code clears pending");

        // R9 edge beats concurrent clear
        pin_set(1'b1);
        wr(8'h34, 32'h1);
        rd(8'h34, 32'h1, "R9 edge wins over ack");
        wr(8'h34, 32'h1);
        rd(8'h34, 32'h0, "R9 later ack clears");

        // R11 unmapped offsets
        rd(8'h28, 32'h0, "R11 unmapped read");
        rd(8'h25, 32'h0, "R11 misaligned read");
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        rd(8'h24, 32'h0000_0100, "R11 ident untouched");
        rd(8'h30, 32'h0000_0003, "R11 trig untouched");

        repeat (2) @(posedge pclk);
        if (sb_q.size() != 0) begin
            n_checks++;
            n_err++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule